// File: doc/BRIEF.md
# Per-Slot Control Bit Serializer

This block sends one control bit for every output stream and channel of a time-division switch on a single serial pin, once per frame. It runs in lockstep with the data streams. The stored bits come from a read port into a memory that holds one control bit per stream and channel. The block fetches one bit per clock and shifts it out, so the pin runs at the same bit rate as the read port.

The bits run one channel ahead of the data they qualify. The sixteen streams are interleaved within each channel period: during the sixteen clocks of channel period k, clock i carries the bit for stream i, channel k+1. The bits for channel 0 are therefore sent during the last channel period of the previous frame.

A two-bit rate code selects 32, 64 or 128 channels per stream. The frame is then 512, 1024 or 2048 bits long. A one-clock frame pulse realigns the position counter. Between pulses the counter wraps freely at the frame length.

Top module: `ctl_bit_serializer`

## Requirements
- R1: While `rst` is high, `ctl_o` is 0 and `rd_addr_o` is 1, which selects stream 0, channel 1.
- R2: Rate code 0, 1 or 2 on `rate_i` gives 32, 64 or 128 channels per stream. The frame is then 512, 1024 or 2048 clocks long.
- R3: In the clock at frame position p, `ctl_o` carries the stored bit for stream p mod 16 and channel (p div 16 + 1) mod C, where C is the channel count. For example, stream 0 channel 0 is sent at position 16·(C−1), and stream 1 channel 0 one clock later.
- R4: The memory address for stream s and channel c is s·C + c. The stream number occupies the bits above the channel field.
- R5: `rd_addr_o` advances by one location each clock. `rd_data_i` is taken to arrive one clock after its address. `ctl_o` shows that bit one clock after it arrives.
- R6: When `fp_i` is high at a rising edge, the clock after that edge is frame position 0. This holds even if the pulse arrives in the middle of a running frame. From position 2 onward, the output follows R3 for the new alignment.
- R7: `rate_i` is sampled only at a frame pulse. A change between pulses has no effect on the output until the next pulse.
- R8: With no frame pulse, the position wraps from the last position back to 0. The same frame sequence then repeats.
- R9: Rate code 3 behaves exactly like rate code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock of the serial control pin |
| rst | input | 1 | Synchronous active-high reset |
| fp_i | input | 1 | Frame pulse; the next clock is frame position 0 |
| rate_i | input | 2 | Rate code: 0 = 32, 1 = 64, 2 or 3 = 128 channels per stream |
| rd_addr_o | output | 11 | Read address into the control-bit memory |
| rd_data_i | input | 1 | Control bit read, valid one clock after its address |
| ctl_o | output | 1 | Serial control bit output |

## Verification
The assertions assume that the frame pulse lasts one clock. They also assume that the memory answers one clock after each address. The bench's memory model is a single registered read, so the second assumption holds throughout. The bench does not score the two positions that follow a pulse which moves the alignment or changes the rate. Those two bits were fetched under the previous alignment or rate. Every other position is scored against a model computed from the memory contents, including the frames in which `rate_i` moves between pulses.

// File: rtl/ctlser_pkg.sv
package ctlser_pkg;

    localparam int SLOT_W   = 4;                       // stream field width
    localparam int STREAMS  = 1 << SLOT_W;
    localparam int CH_W0    = 5;                       // channel width at lowest rate
    localparam int MAX_RATE = 2;                       // highest legal rate code
    localparam int POS_W    = SLOT_W + CH_W0 + MAX_RATE;
    localparam int ADDR_W   = POS_W;
    localparam int LEAD     = 2;                       // fetch lead: RAM + output reg

    typedef enum logic [1:0] {
        RATE_LO  = 2'd0,
        RATE_MID = 2'd1,
        RATE_HI  = 2'd2,
        RATE_RSV = 2'd3
    } rate_e;

    typedef struct packed {
        logic [POS_W-SLOT_W-1:0] period;   // channel period index
        logic [SLOT_W-1:0]       stream;   // slot within the period
    } pos_t;

    function automatic rate_e legal_rate(input logic [1:0] code);
        return (code == 2'd3) ? RATE_HI : rate_e'(code);
    endfunction

    function automatic logic [POS_W-1:0] chan_mask(input rate_e r);
        return POS_W'((32'd1 << (CH_W0 + int'(r))) - 32'd1);
    endfunction

    function automatic logic [POS_W-1:0] last_pos(input rate_e r);
        return POS_W'((32'd1 << (SLOT_W + CH_W0 + int'(r))) - 32'd1);
    endfunction

    function automatic logic [ADDR_W-1:0] pack_addr(input logic [SLOT_W-1:0] s,
                                                    input logic [POS_W-1:0]  ch,
                                                    input rate_e             r);
        logic [ADDR_W-1:0] wide;
        wide = ADDR_W'(s);
        return (wide << (CH_W0 + int'(r))) | (ch & chan_mask(r));
    endfunction

    function automatic logic [SLOT_W-1:0] addr_stream(input logic [ADDR_W-1:0] a,
                                                      input rate_e             r);
        return SLOT_W'(a >> (CH_W0 + int'(r)));
    endfunction

    function automatic logic [POS_W-1:0] addr_chan(input logic [ADDR_W-1:0] a,
                                                   input rate_e             r);
        return a & chan_mask(r);
    endfunction

endpackage

// File: rtl/ctlser_frame_ctr.sv
module ctlser_frame_ctr
    import ctlser_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fp_i,
    input  logic [1:0]       rate_i,
    output logic [POS_W-1:0] fcnt,
    output rate_e            rate_q
);
    // fcnt is the fetch position, LEAD clocks ahead of the frame position
    always_ff @(posedge clk) begin
        if (rst) begin
            fcnt   <= '0;
            rate_q <= RATE_LO;
        end else if (fp_i) begin
            fcnt   <= POS_W'(LEAD);
            rate_q <= legal_rate(rate_i);
        end else if (fcnt == last_pos(rate_q)) begin
            fcnt   <= '0;
        end else begin
            fcnt   <= fcnt + 1'b1;
        end
    end
endmodule

// File: rtl/ctlser_addr_map.sv
module ctlser_addr_map
    import ctlser_pkg::*;
(
    input  logic [POS_W-1:0]  fcnt,
    input  rate_e             rate_q,
    output logic [ADDR_W-1:0] rd_addr
);
    pos_t             pos;
    logic [POS_W-1:0] next_ch;

    always_comb begin
        pos     = pos_t'(fcnt);
        // one channel ahead, wrapping at the channel count of the rate
        next_ch = (POS_W'(pos.period) + 1'b1) & chan_mask(rate_q);
        rd_addr = pack_addr(pos.stream, next_ch, rate_q);
    end
endmodule

// File: rtl/ctlser_out_stage.sv
module ctlser_out_stage (
    input  logic clk,
    input  logic rst,
    input  logic bit_i,
    output logic bit_o
);
    always_ff @(posedge clk) begin
        if (rst) bit_o <= 1'b0;
        else     bit_o <= bit_i;
    end
endmodule

// File: rtl/ctl_bit_serializer.sv
module ctl_bit_serializer
    import ctlser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fp_i,
    input  logic [1:0]        rate_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_data_i,
    output logic              ctl_o
);
    logic [POS_W-1:0] fcnt;
    rate_e            rate_q;

    ctlser_frame_ctr u_ctr (
        .clk    (clk),
        .rst    (rst),
        .fp_i   (fp_i),
        .rate_i (rate_i),
        .fcnt   (fcnt),
        .rate_q (rate_q)
    );

    ctlser_addr_map u_map (
        .fcnt    (fcnt),
        .rate_q  (rate_q),
        .rd_addr (rd_addr_o)
    );

    ctlser_out_stage u_out (
        .clk   (clk),
        .rst   (rst),
        .bit_i (rd_data_i),
        .bit_o (ctl_o)
    );
endmodule

// File: rtl/ctl_bit_serializer_chk.sv
module ctl_bit_serializer_chk
    import ctlser_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              fp_i,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic [POS_W-1:0]  fcnt,
    input rate_e             rate_q
);
    // R6: a pulse puts the fetch two positions ahead: stream 2, channel 1
    p_frame_start_r6: assert property (@(posedge clk) disable iff (rst)
        fp_i |=> (addr_stream(rd_addr_o, rate_q) == SLOT_W'(2)) &&
                 (addr_chan(rd_addr_o, rate_q) == POS_W'(1)));

    // R3: inside a channel period the stream steps, the channel holds
    p_slot_step_r3: assert property (@(posedge clk) disable iff (rst)
        (!fp_i && fcnt[SLOT_W-1:0] != {SLOT_W{1'b1}}) |=>
            (addr_stream(rd_addr_o, rate_q) ==
             SLOT_W'(addr_stream($past(rd_addr_o), rate_q) + 1'b1)) &&
            (addr_chan(rd_addr_o, rate_q) == addr_chan($past(rd_addr_o), rate_q)));

    // R8: free-running wrap at the frame length
    p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (!fp_i && fcnt == last_pos(rate_q)) |=> (fcnt == '0));

    // R7: rate only changes on a pulse
    p_rate_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !fp_i |=> $stable(rate_q));

    // R9: the reserved code never becomes the working rate
    p_rate_legal_r9: assert property (@(posedge clk) disable iff (rst)
        rate_q != RATE_RSV);
endmodule

bind ctl_bit_serializer ctl_bit_serializer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .fp_i      (fp_i),
    .rd_addr_o (rd_addr_o),
    .fcnt      (fcnt),
    .rate_q    (rate_q)
);

// File: tb/sim_ctl_bit_serializer.sv
`timescale 1ns/1ps
module sim_ctl_bit_serializer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fp_i = 1'b0;
    logic [1:0]  rate_i = 2'd0;
    logic [10:0] rd_addr_o;
    logic        rd_data_i = 1'b0;
    logic        ctl_o;
    logic        mem [2048];
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    ctl_bit_serializer u0 (
        .clk       (clk),
        .rst       (rst),
        .fp_i      (fp_i),
        .rate_i    (rate_i),
        .rd_addr_o (rd_addr_o),
        .rd_data_i (rd_data_i),
        .ctl_o     (ctl_o)
    );

    // registered read memory: data one clock after its address
    always_ff @(posedge clk) rd_data_i <= mem[rd_addr_o];

    function automatic int eff_rate(input int r);
        return (r == 3) ? 2 : r;
    endfunction

    function automatic int nchan(input int r);
        return 32 << eff_rate(r);
    endfunction

    function automatic int fbits(input int r);
        return 16 * nchan(r);
    endfunction

    function automatic bit exp_bit(input int p, input int r);
        int s;
        int ch;
        s  = p % 16;
        ch = ((p / 16) + 1) % nchan(r);
        return mem[s * nchan(r) + ch];
    endfunction

    task automatic check(input logic got, input logic exp, input string req, input int p);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s pos %0d: got %0b expected %0b", req, p, got, exp);
        end
    endtask

    task automatic fill_random();
        for (int i = 0; i < 2048; i++) mem[i] = 1'($urandom);
    endtask

    // called at a negedge; each following negedge is one frame position
    task automatic frame(input bit pulse, input int r, input int first_chk,
                         input int last_p, input string req,
                         input int chg_at, input int new_rate);
        if (pulse) fp_i = 1'b1;
        for (int p = 0; p <= last_p; p++) begin
            @(negedge clk);
            fp_i = 1'b0;
            if (p >= first_chk) check(ctl_o, exp_bit(p, r), req, p);
            if (p == chg_at) rate_i = 2'(new_rate);
        end
    endtask

    initial begin
        int rates [8];
        void'($urandom(32'd4242));
        fill_random();
        repeat (3) @(negedge clk);
        check(ctl_o, 1'b0, "R1", -1);
        check(rd_addr_o == 11'd1, 1'b1, "R1", -1);
        rst = 1'b0;

        // R4 R5 directed: only stream 0 ch 0 and stream 1 ch 0 set
        for (int i = 0; i < 2048; i++) mem[i] = 1'b0;
        mem[0]  = 1'b1;
        mem[32] = 1'b1;
        rate_i  = 2'd0;
        frame(1, 0, 9999, 511, "", -1, 0);
        frame(1, 0, 0, 511, "R4 R5", -1, 0);
        check(exp_bit(496, 0), 1'b1, "R3", 496);
        check(exp_bit(497, 0), 1'b1, "R3", 497);

        // per-rate frames, directed then random rate codes
        rates = '{0, 1, 2, 3, 0, 0, 0, 0};
        for (int k = 4; k < 8; k++) rates[k] = int'($urandom % 4);
        for (int k = 0; k < 8; k++) begin
            fill_random();
            rate_i = 2'(rates[k]);
            frame(1, rates[k], 9999, fbits(rates[k]) - 1, "", -1, 0);
            frame(1, rates[k], 0, fbits(rates[k]) - 1,
                  (rates[k] == 3) ? "R9" : "R2 R3", -1, 0);
            frame(0, rates[k], 0, fbits(rates[k]) - 1, "R8", -1, 0);
        end

        // R7: rate moves mid-frame, old pattern continues until next pulse
        fill_random();
        rate_i = 2'd0;
        frame(1, 0, 9999, 511, "", -1, 0);
        frame(1, 0, 0, 511, "R7", 100, 2);
        frame(0, 0, 0, 511, "R7", -1, 0);
        frame(1, 2, 2, 2047, "R7", -1, 0);

        // R6: a pulse in mid-frame realigns the position
        rate_i = 2'd1;
        frame(1, 1, 9999, 1023, "", -1, 0);
        frame(0, 1, 0, 199, "R6", -1, 0);
        frame(1, 1, 2, 1023, "R6", -1, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule